// File: doc/BRIEF.md
# Serial Character Transmitter with Break Override and Clear-to-Send Gating

This block turns 8-bit characters into an asynchronous serial stream on a single output line. A character goes first into a one-entry holding register. From there it moves into a shift register on a bit tick, and each bit is then held on the line for one tick period. Behind the data byte the frame can carry nothing extra, an even parity bit, or a software-set ninth bit. That ninth bit lives in the control register, is not buffered, and clears itself once the character carrying it has started.

Two control bits change what appears on the line. A break bit forces the output low whatever the shifter is doing, while the shifter keeps its normal timing. Because of this, software can time a break by writing ordinary characters and waiting for the empty status to return. A flow-control bit makes the clear-to-send input gate the start of each character. A character already on the line always runs to its end.

The block has two status outputs. A transmitter-empty flag shows that both the holding register and the shift register are empty. A DMA request, generated inside the block, stays high while the holding register can accept another character. Baud-rate generation, the receiver and any bus interface belong to other blocks.

Top module: `serial_tx_brk`

## Requirements
- R1: After reset, txd is 1, tx_empty is 1, dma_req is 1, and break, ninth bit and flow control are all 0, so cts has no effect.
- R2: The frame is a 0 start bit, then the data LSB first, then the optional extra bit, then a 1 stop bit. Each bit lasts one tick period. A character written while the transmitter is idle starts at the next tick.
- R3: The ctl_mode encoding is: 00 gives 8 data bits (a 10-bit frame); 01 adds an even parity bit (the XOR of the data bits); 10 and 11 add the ninth-bit control value as a ninth data bit (an 11-bit frame).
- R4: The ninth-bit control clears when a character moves into the shift register, unless a control write occurs in the same cycle. The next character then carries 0 in that position unless software sets the bit again.
- R5: While the break bit is 1, txd is 0 whatever is being shifted. Characters still shift with normal timing, and tx_empty returns to 1 when they are done.
- R6: With flow control on, a character does not start while cts is 0. It starts at the first tick with cts at 1. A character already started completes even if cts drops.
- R7: With flow control off, cts has no effect on when a character starts.
- R8: A write is accepted only while the holding register is empty. A write while it is full is discarded, so one character can wait while another shifts.
- R9: tx_empty is 1 exactly when neither the holding register nor the shift register holds a character. dma_req is 1 while the holding register is empty.
- R10: When a character is waiting, its start bit follows the previous stop bit with no idle bit in between.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Character write strobe |
| wr_data | input | 8 | Character to send |
| ctl_wr | input | 1 | Control register write strobe |
| ctl_brk | input | 1 | Break value to write |
| ctl_nine | input | 1 | Ninth-bit value to write |
| ctl_fc | input | 1 | Flow-control enable to write |
| ctl_mode | input | 2 | Frame mode to write |
| cts | input | 1 | Clear to send, active high |
| tick | input | 1 | One-cycle pulse per bit period |
| txd | output | 1 | Serial output line, idle high |
| tx_empty | output | 1 | Holding and shift registers both empty |
| dma_req | output | 1 | Internal DMA request: holding register empty |

## Verification
A wrong bit counter or a wrong frame length shows up within one character: a stop bit is missing or extra, or the next start bit is shifted. A frame compared bit by bit catches it at the following tick. If the ninth bit fails to clear, or the holding register is overwritten, the error appears only on the next character, one frame later. Flow-control and break faults change txd at the first tick after the triggering condition. An exhaustive sweep of every data byte in every mode exposes any fault in bit order or parity.

// File: rtl/serial_tx_brk.sv
module serial_tx_brk #(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              ctl_wr,
  input  logic              ctl_brk,
  input  logic              ctl_nine,
  input  logic              ctl_fc,
  input  logic [1:0]        ctl_mode,
  input  logic              cts,
  input  logic              tick,
  output logic              txd,
  output logic              tx_empty,
  output logic              dma_req
);
  localparam int FRAME_W = DATA_W + 3;
  localparam int CNT_W = $clog2(FRAME_W);
  localparam logic [CNT_W-1:0] LAST_X = CNT_W'(FRAME_W - 1);
  localparam logic [CNT_W-1:0] LAST_N = CNT_W'(FRAME_W - 2);

  logic brk_q, nine_q, fc_q;
  logic [1:0] mode_q;
  logic hold_v;
  logic [DATA_W-1:0] hold_d;
  logic busy;
  logic [FRAME_W-1:0] sh;
  logic [CNT_W-1:0] cnt, last_q;

  wire has_x = mode_q != 2'b00;
  wire xbit = mode_q[1] ? nine_q : ^hold_d;
  wire slot_free = !busy || (cnt == last_q);
  wire cts_ok = !fc_q || cts;
  wire load = tick && slot_free && hold_v && cts_ok;
  wire [FRAME_W-1:0] frame = has_x ? {1'b1, xbit, hold_d, 1'b0}
                                   : {2'b11, hold_d, 1'b0};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      brk_q  <= 1'b0;
      nine_q <= 1'b0;
      fc_q   <= 1'b0;
      mode_q <= 2'b00;
    end else if (ctl_wr) begin
      brk_q  <= ctl_brk;
      nine_q <= ctl_nine;
      fc_q   <= ctl_fc;
      mode_q <= ctl_mode;
    end else if (load) begin
      nine_q <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      hold_v <= 1'b0;
      hold_d <= '0;
    end else if (load) begin
      hold_v <= 1'b0;
    end else if (wr_en && !hold_v) begin
      hold_v <= 1'b1;
      hold_d <= wr_data;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy   <= 1'b0;
      sh     <= '1;
      cnt    <= '0;
      last_q <= LAST_N;
    end else if (tick) begin
      if (load) begin
        busy   <= 1'b1;
        sh     <= frame;
        cnt    <= '0;
        last_q <= has_x ? LAST_X : LAST_N;
      end else if (busy) begin
        if (cnt == last_q) begin
          busy <= 1'b0;
        end else begin
          sh  <= {1'b1, sh[FRAME_W-1:1]};
          cnt <= cnt + 1'b1;
        end
      end
    end
  end

  assign txd      = brk_q ? 1'b0 : (busy ? sh[0] : 1'b1);
  assign tx_empty = !hold_v && !busy;
  assign dma_req  = !hold_v;
endmodule

module serial_tx_brk_chk #(
  parameter int DATA_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              wr_en,
  input logic              ctl_wr,
  input logic              cts,
  input logic              txd,
  input logic              tx_empty,
  input logic              dma_req,
  input logic              brk_q,
  input logic              nine_q,
  input logic              fc_q,
  input logic              busy,
  input logic              hold_v,
  input logic [DATA_W-1:0] hold_d
);
  AST_BREAK_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    brk_q |-> !txd); // R5
  AST_START_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> !txd); // R2
  AST_NINE_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) && !$past(ctl_wr) |-> !nine_q); // R4
  AST_CTS_GATE: assert property (@(posedge clk) disable iff (!rst_n)
    fc_q && !cts && !busy |=> !busy); // R6
  AST_FULL_DROP: assert property (@(posedge clk) disable iff (!rst_n)
    hold_v && wr_en |=> hold_d == $past(hold_d)); // R8
  AST_EMPTY_REQ: assert property (@(posedge clk) disable iff (!rst_n)
    tx_empty |-> dma_req); // R9
  AST_EMPTY_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    tx_empty && !brk_q |-> txd); // R9
endmodule

bind serial_tx_brk serial_tx_brk_chk #(.DATA_W(DATA_W)) chk_i (
  .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .ctl_wr(ctl_wr), .cts(cts),
  .txd(txd), .tx_empty(tx_empty), .dma_req(dma_req), .brk_q(brk_q),
  .nine_q(nine_q), .fc_q(fc_q), .busy(busy), .hold_v(hold_v), .hold_d(hold_d)
);

// File: tb/serial_tx_brk_tb_top.sv
`timescale 1ns/1ps
module serial_tx_brk_tb_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic wr_en = 1'b0;
  logic [7:0] wr_data = '0;
  logic ctl_wr = 1'b0, ctl_brk = 1'b0, ctl_nine = 1'b0, ctl_fc = 1'b0;
  logic [1:0] ctl_mode = 2'b00;
  logic cts = 1'b0;
  logic tick = 1'b0;
  logic txd, tx_empty, dma_req;
  int n_chk = 0, n_bad = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  serial_tx_brk dut_i (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
    .ctl_wr(ctl_wr), .ctl_brk(ctl_brk), .ctl_nine(ctl_nine), .ctl_fc(ctl_fc),
    .ctl_mode(ctl_mode), .cts(cts), .tick(tick),
    .txd(txd), .tx_empty(tx_empty), .dma_req(dma_req)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic do_tick();
    @(negedge clk) tick = 1'b1;
    @(negedge clk) tick = 1'b0;
  endtask

  task automatic wr(input logic [7:0] d);
    @(negedge clk) begin wr_en = 1'b1; wr_data = d; end
    @(negedge clk) wr_en = 1'b0;
  endtask

  task automatic ctl(input logic b, input logic n, input logic f, input logic [1:0] m);
    @(negedge clk) begin
      ctl_wr = 1'b1; ctl_brk = b; ctl_nine = n; ctl_fc = f; ctl_mode = m;
    end
    @(negedge clk) ctl_wr = 1'b0;
  endtask

  task automatic cap(input int n, output logic [10:0] v);
    v = '0;
    for (int i = 0; i < n; i++) begin
      do_tick();
      v[i] = txd;
    end
  endtask

  function automatic logic [10:0] exp_frame(logic [7:0] d, logic [1:0] m, logic n);
    if (m == 2'b00) return {2'b01, d, 1'b0};
    return {1'b1, (m[1] ? n : ^d), d, 1'b0};
  endfunction

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual 0 expected 1");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    logic [10:0] got, rest, e;
    logic b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(txd == 1'b1, "R1 txd idle", txd, 1);
    chk(tx_empty == 1'b1, "R1 empty", tx_empty, 1);
    chk(dma_req == 1'b1, "R1 dma_req", dma_req, 1);

    // R7 and R1: cts low after reset, flow control off
    wr(8'h5A);
    chk(tx_empty == 1'b0, "R9 busy after write", tx_empty, 0);
    cap(10, got);
    chk(got == exp_frame(8'h5A, 2'b00, 1'b0), "R7 cts ignored", got, exp_frame(8'h5A, 2'b00, 1'b0));
    do_tick();
    chk(tx_empty == 1'b1, "R9 empty after frame", tx_empty, 1);

    // R2 R3: exhaustive sweep of data in every mode
    for (int m = 0; m < 4; m++) begin
      for (int d = 0; d < 256; d++) begin
        logic nn;
        nn = d[0] ^ m[0];
        ctl(1'b0, nn, 1'b0, 2'(m));
        wr(8'(d));
        cap((m == 0) ? 10 : 11, got);
        e = exp_frame(8'(d), 2'(m), nn);
        chk(got == e, "R3 frame", got, e);
        do_tick();
        chk(tx_empty == 1'b1 && txd == 1'b1, "R2 idle after stop", {tx_empty, txd}, 3);
      end
    end

    // R4: ninth bit self-clears
    ctl(1'b0, 1'b1, 1'b0, 2'b10);
    wr(8'h3C);
    cap(11, got);
    chk(got == exp_frame(8'h3C, 2'b10, 1'b1), "R4 ninth set", got, exp_frame(8'h3C, 2'b10, 1'b1));
    do_tick();
    wr(8'h3C);
    cap(11, got);
    chk(got == exp_frame(8'h3C, 2'b10, 1'b0), "R4 ninth cleared", got, exp_frame(8'h3C, 2'b10, 1'b0));
    do_tick();

    // R5: break
    ctl(1'b1, 1'b0, 1'b0, 2'b00);
    chk(txd == 1'b0, "R5 break idle", txd, 0);
    wr(8'hFF);
    cap(10, got);
    chk(got == 11'h000, "R5 break frame", got, 0);
    do_tick();
    chk(tx_empty == 1'b1 && txd == 1'b0, "R5 empty under break", {tx_empty, txd}, 2);
    ctl(1'b0, 1'b0, 1'b0, 2'b00);
    chk(txd == 1'b1, "R5 release", txd, 1);

    // R6: flow control
    ctl(1'b0, 1'b0, 1'b1, 2'b00);
    cts = 1'b0;
    wr(8'hA5);
    for (int i = 0; i < 3; i++) begin
      do_tick();
      chk(txd == 1'b1 && tx_empty == 1'b0, "R6 held off", {txd, tx_empty}, 2);
    end
    cts = 1'b1;
    do_tick();
    b0 = txd;
    cts = 1'b0;
    cap(9, rest);
    got = {rest[9:0], b0};
    chk(got == exp_frame(8'hA5, 2'b00, 1'b0), "R6 completes", got, exp_frame(8'hA5, 2'b00, 1'b0));
    do_tick();
    chk(tx_empty == 1'b1, "R6 empty", tx_empty, 1);
    cts = 1'b1;

    // R8 R10: holding register and back-to-back
    ctl(1'b0, 1'b0, 1'b0, 2'b00);
    wr(8'h81);
    chk(dma_req == 1'b0, "R9 dma_req full", dma_req, 0);
    do_tick();
    b0 = txd;
    chk(dma_req == 1'b1, "R9 dma_req after load", dma_req, 1);
    wr(8'h42);
    wr(8'h99);
    chk(dma_req == 1'b0, "R8 holding full", dma_req, 0);
    cap(9, rest);
    got = {rest[9:0], b0};
    chk(got == exp_frame(8'h81, 2'b00, 1'b0), "R8 first frame", got, exp_frame(8'h81, 2'b00, 1'b0));
    cap(10, got);
    chk(got == exp_frame(8'h42, 2'b00, 1'b0), "R10 no gap", got, exp_frame(8'h42, 2'b00, 1'b0));
    do_tick();
    chk(tx_empty == 1'b1 && txd == 1'b1, "R8 dropped write", {tx_empty, txd}, 3);

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule